// File: doc/BRIEF.md
# Dual-Period Watchdog Timer

This block watches a processor's periodic "kick" line and raises a one-cycle fault strobe when the line has not changed state within the allowed window. The strobe is meant to drive an external reset pulse generator. The kick line arrives already digitised: a logic level, and a separate disable flag that means the pin was left floating or held at mid-supply. Either direction of change on the level counts as a kick. When the disable flag is set, monitoring is suspended.

The window is counted in timebase ticks. One of two periods applies. A long grace period is in force after every reset. A short period can be chosen, but it arms only once the processor has kicked at least once after reset is released. The internal and external timebases use different long periods. The block also drives a registered, active-high "watchdog healthy" status. This status drops on a timeout and recovers on the next kick made outside reset. A low-line condition forces it high.

The host feeds in three things from the surrounding supervisor: the reset state, a one-cycle reset-end pulse and the low-line flag. The mode selects are captured only while reset is held, so the period never changes mid-count.

Top module: `wdp_watchdog`

## Requirements
- R1: A rising or a falling change on `kick_in` restarts the count. With `tick` high every cycle and period P, `fault_strobe` reads high exactly 3+P clock cycles after `kick_in` changes. Two of those cycles are the input synchroniser and one is the change detector.
- R2: While `kick_off` is 1, no fault strobe is produced and `wdog_ok` is 1. When `kick_off` returns to 0, counting resumes from zero. The strobe then reads high 2+P cycles after the flag falls.
- R3: Periods are parameters. The short period defaults to 1024 ticks. The long period defaults to 16384 ticks with the internal timebase (`ext_tb`=0) and to 4096 ticks with the external timebase (`ext_tb`=1).
- R4: After any reset the long period applies. A short selection (`short_sel`=1) takes effect only after the first kick seen while `rst_active` is 0.
- R5: Kicks made while `rst_active` is 1 do not arm the short period, do not restart the count and do not set `wdog_ok`. No strobe is produced while `rst_active` is 1.
- R6: A `rst_done` pulse restarts the count. The strobe reads high 1+P cycles after the pulse is applied.
- R7: `fault_strobe` is high for one cycle per timeout. If the input stays static, another strobe follows every P cycles.
- R8: `wdog_ok` falls in the cycle the strobe rises. It returns to 1 only after a kick made while `rst_active` is 0, one cycle after the change is detected.
- R9: While `low_line` is 1, `wdog_ok` is held at 1, including across a timeout.
- R10: `ext_tb` and `short_sel` are sampled only while `rst_active` is 1. Changes made outside reset have no effect until the next reset.
- R11: After the block reset `rst`, `wdog_ok` is 1 and `fault_strobe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| tick | input | 1 | Timebase tick enable |
| kick_in | input | 1 | Digitised kick level (asynchronous) |
| kick_off | input | 1 | Disable flag: input floating or mid-supply (asynchronous) |
| rst_active | input | 1 | System reset currently asserted |
| rst_done | input | 1 | One-cycle pulse at the end of a system reset |
| low_line | input | 1 | Low supply condition |
| ext_tb | input | 1 | 1 selects the external timebase period set |
| short_sel | input | 1 | 1 selects the short period once armed |
| fault_strobe | output | 1 | One-cycle timeout strobe |
| wdog_ok | output | 1 | Latched watchdog status, 0 after a timeout |

## Verification
The checker assumes that `rst_active` is held for at least one cycle before any `rst_done` pulse and that the default periods exceed one tick. It also assumes that `kick_off` stays at a defined level for three cycles around the window it checks. The bench keeps to these assumptions. It holds reset for several cycles before every release, and it changes `kick_off` only at a falling clock edge and leaves it steady for hundreds of cycles. It runs with small period overrides. Random kick spacing is drawn from a range strictly shorter than the active period, so every strobe the bench sees comes from a deliberate stall.

// File: rtl/wdp_pkg.sv
package wdp_pkg;
  typedef struct packed {
    logic ext;
    logic short_req;
  } wdp_mode_t;
endpackage

// File: rtl/wdp_sync.sv
module wdp_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage[s] <= '0;
        else     stage[s] <= stage[s-1];
      end
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/wdp_period.sv
module wdp_period
  import wdp_pkg::*;
#(
  parameter int SHORT_TICKS    = 1024,
  parameter int LONG_INT_TICKS = 16384,
  parameter int LONG_EXT_TICKS = 4096,
  parameter int CNT_W          = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rst_active,
  input  logic             ext_tb,
  input  logic             short_sel,
  input  logic             kick_ok,
  output logic [CNT_W-1:0] period
);
  localparam logic [CNT_W-1:0] P_SHORT = CNT_W'(SHORT_TICKS);
  localparam logic [CNT_W-1:0] P_LINT  = CNT_W'(LONG_INT_TICKS);
  localparam logic [CNT_W-1:0] P_LEXT  = CNT_W'(LONG_EXT_TICKS);

  wdp_mode_t mode_q;
  logic      armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      armed_q <= 1'b0;
    end else if (rst_active) begin
      mode_q  <= '{ext: ext_tb, short_req: short_sel};
      armed_q <= 1'b0;
    end else if (kick_ok) begin
      armed_q <= 1'b1;
    end
  end

  always_comb begin
    if (armed_q && mode_q.short_req) period = P_SHORT;
    else if (mode_q.ext)             period = P_LEXT;
    else                             period = P_LINT;
  end
endmodule

// File: rtl/wdp_count.sv
module wdp_count #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] period,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q  <= '0;
      expire <= 1'b0;
    end else if (tick) begin
      if (cnt_q >= period - 1'b1) begin
        cnt_q  <= '0;
        expire <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        expire <= 1'b0;
      end
    end else begin
      expire <= 1'b0;
    end
  end
endmodule

// File: rtl/wdp_watchdog.sv
module wdp_watchdog #(
  parameter int SHORT_TICKS    = 1024,
  parameter int LONG_INT_TICKS = 16384,
  parameter int LONG_EXT_TICKS = 4096,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic kick_in,
  input  logic kick_off,
  input  logic rst_active,
  input  logic rst_done,
  input  logic low_line,
  input  logic ext_tb,
  input  logic short_sel,
  output logic fault_strobe,
  output logic wdog_ok
);
  localparam int MAX_A = (LONG_INT_TICKS > LONG_EXT_TICKS) ? LONG_INT_TICKS : LONG_EXT_TICKS;
  localparam int MAX_P = (MAX_A > SHORT_TICKS) ? MAX_A : SHORT_TICKS;
  localparam int CNT_W = $clog2(MAX_P + 1);

  logic [1:0]       raw_in, sync_out;
  logic             kick_s, off_s, kick_prev;
  logic             kick_edge, kick_ok, cnt_clear;
  logic [CNT_W-1:0] period;

  assign raw_in = {kick_off, kick_in};

  wdp_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d (raw_in), .q (sync_out)
  );

  assign kick_s = sync_out[0];
  assign off_s  = sync_out[1];

  always_ff @(posedge clk) begin
    if (rst) kick_prev <= 1'b0;
    else     kick_prev <= kick_s;
  end

  assign kick_edge = kick_s ^ kick_prev;
  assign kick_ok   = kick_edge && !rst_active && !off_s;
  assign cnt_clear = rst_active || rst_done || off_s || kick_ok;

  wdp_period #(
    .SHORT_TICKS    (SHORT_TICKS),
    .LONG_INT_TICKS (LONG_INT_TICKS),
    .LONG_EXT_TICKS (LONG_EXT_TICKS),
    .CNT_W          (CNT_W)
  ) u_period (
    .clk (clk), .rst (rst), .rst_active (rst_active),
    .ext_tb (ext_tb), .short_sel (short_sel), .kick_ok (kick_ok),
    .period (period)
  );

  wdp_count #(.CNT_W(CNT_W)) u_count (
    .clk (clk), .rst (rst), .clear (cnt_clear), .tick (tick),
    .period (period), .expire (fault_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst)                   wdog_ok <= 1'b1;
    else if (low_line || off_s) wdog_ok <= 1'b1;
    else if (cnt_clear)         wdog_ok <= kick_ok ? 1'b1 : wdog_ok;
    else if (tick && (u_count.cnt_q >= period - 1'b1)) wdog_ok <= 1'b0;
  end
endmodule

// File: rtl/wdp_watchdog_chk.sv
module wdp_watchdog_chk (
  input logic clk,
  input logic rst,
  input logic kick_off,
  input logic rst_active,
  input logic low_line,
  input logic fault_strobe,
  input logic wdog_ok
);
  a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fault_strobe |=> !fault_strobe);

  a_r9_lowline_forces_ok: assert property (@(posedge clk) disable iff (rst)
    low_line |=> wdog_ok);

  a_r8_ok_falls_with_strobe: assert property (@(posedge clk) disable iff (rst)
    $fell(wdog_ok) |-> fault_strobe);

  a_r5_no_strobe_in_reset: assert property (@(posedge clk) disable iff (rst)
    rst_active |=> !fault_strobe);

  a_r2_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
     $past(kick_off, 2) && $past(kick_off, 3)) |-> (!fault_strobe && wdog_ok));
endmodule

bind wdp_watchdog wdp_watchdog_chk u_chk (
  .clk (clk), .rst (rst), .kick_off (kick_off), .rst_active (rst_active),
  .low_line (low_line), .fault_strobe (fault_strobe), .wdog_ok (wdog_ok)
);

// File: tb/wdp_watchdog_tb.sv
module wdp_watchdog_tb;
  localparam int PS  = 16;
  localparam int PLI = 64;
  localparam int PLE = 32;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b1, kick_in = 1'b0, kick_off = 1'b0;
  logic rst_active = 1'b1, rst_done = 1'b0, low_line = 1'b0;
  logic ext_tb = 1'b0, short_sel = 1'b0;
  logic fault_strobe, wdog_ok;

  int checks = 0, errors = 0, cycles = 0, strobes = 0;
  logic m_ext = 1'b0, m_short = 1'b0, armed = 1'b0;

  always #5 clk = ~clk;

  wdp_watchdog #(.SHORT_TICKS(PS), .LONG_INT_TICKS(PLI), .LONG_EXT_TICKS(PLE)) u_dut (
    .clk (clk), .rst (rst), .tick (tick), .kick_in (kick_in), .kick_off (kick_off),
    .rst_active (rst_active), .rst_done (rst_done), .low_line (low_line),
    .ext_tb (ext_tb), .short_sel (short_sel),
    .fault_strobe (fault_strobe), .wdog_ok (wdog_ok)
  );

  function automatic int exp_period(logic e, logic s, logic a);
    if (a && s) return PS;
    return e ? PLE : PLI;
  endfunction

  task automatic check(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (fault_strobe) strobes++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      rst_done = 1'b0;
      n++;
    end while (!fault_strobe && n < 400);
  endtask

  task automatic enter_reset(logic e, logic s);
    @(negedge clk);
    rst_active = 1'b1; ext_tb = e; short_sel = s;
    repeat (5) @(negedge clk);
    m_ext = e; m_short = s; armed = 1'b0;
  endtask

  task automatic leave_reset(string req);
    int n;
    rst_active = 1'b0; rst_done = 1'b1;
    wait_strobe(n);
    check(n == 1 + exp_period(m_ext, m_short, armed), req, n, 1 + exp_period(m_ext, m_short, armed));
  endtask

  task automatic kick_measure(string req);
    int n; logic ok4;
    kick_in = ~kick_in;
    n = 0; ok4 = 1'b0;
    do begin
      @(negedge clk);
      n++;
      if (n == 4) ok4 = wdog_ok;
    end while (!fault_strobe && n < 400);
    armed = 1'b1;
    check(n == 3 + exp_period(m_ext, m_short, armed), req, n, 3 + exp_period(m_ext, m_short, armed));
    check(ok4 == 1'b1, "R8 ok restored by kick", int'(ok4), 1);
  endtask

  initial begin
    int n, s0;
    repeat (4) @(negedge clk);
    check(wdog_ok == 1'b1 && fault_strobe == 1'b0, "R11 reset state", int'(wdog_ok), 1);
    rst = 1'b0;

    // R4 R6: internal timebase, short requested, long until first kick
    enter_reset(1'b0, 1'b1);
    leave_reset("R4 R6 long after reset");
    @(negedge clk);
    check(fault_strobe == 1'b0, "R7 strobe one cycle", int'(fault_strobe), 0);
    check(wdog_ok == 1'b0, "R8 ok low after timeout", int'(wdog_ok), 0);
    wait_strobe(n);
    check(n == PLI - 1, "R7 repeat period", n, PLI - 1);

    // R1: rising then falling kick, short now armed
    kick_measure("R1 R4 rising kick short armed");
    kick_measure("R1 falling kick");

    // R10: select change outside reset ignored
    short_sel = 1'b0; ext_tb = 1'b1;
    kick_measure("R10 mode held outside reset");

    // R5: kicks during reset ignored
    enter_reset(1'b0, 1'b1);
    kick_in = ~kick_in;
    s0 = strobes;
    repeat (6) @(negedge clk);
    check(wdog_ok == 1'b0, "R5 ok not set by kick in reset", int'(wdog_ok), 0);
    check(strobes == s0, "R5 no strobe in reset", strobes - s0, 0);
    leave_reset("R5 kick in reset does not arm");

    // R3: external timebase periods
    enter_reset(1'b1, 1'b0);
    leave_reset("R3 external long");
    kick_measure("R3 external long after kick");
    enter_reset(1'b1, 1'b1);
    leave_reset("R3 external long grace");
    kick_measure("R3 external short");

    // R9: low-line forces ok high across a timeout
    low_line = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(wdog_ok == 1'b1, "R9 ok forced high", int'(wdog_ok), 1);
    wait_strobe(n);
    @(negedge clk);
    check(wdog_ok == 1'b1, "R9 ok high across timeout", int'(wdog_ok), 1);
    low_line = 1'b0;
    wait_strobe(n);
    @(negedge clk);
    check(wdog_ok == 1'b0, "R8 ok low after timeout", int'(wdog_ok), 0);

    // R2: disable flag
    kick_off = 1'b1;
    s0 = strobes;
    repeat (200) @(negedge clk);
    check(strobes == s0, "R2 no strobe when disabled", strobes - s0, 0);
    check(wdog_ok == 1'b1, "R2 ok high when disabled", int'(wdog_ok), 1);
    kick_off = 1'b0;
    wait_strobe(n);
    check(n == 2 + exp_period(m_ext, m_short, armed), "R2 restart after enable", n, 2 + exp_period(m_ext, m_short, armed));

    // R1: random kick spacing shorter than the period keeps it quiet
    void'($urandom(32'd1234));
    @(negedge clk);
    s0 = strobes;
    for (int i = 0; i < 25; i++) begin
      kick_in = ~kick_in;
      repeat (2 + ($urandom % (PS - 2))) @(negedge clk);
    end
    check(strobes == s0, "R1 random kicks prevent timeout", strobes - s0, 0);
    kick_measure("R1 timeout after last random kick");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule